// File: doc/BRIEF.md
# DMA Status and Interrupt Combiner

This block keeps the DMA command, working byte count and DMA status registers of a PCI SCSI host adapter. It drives the adapter's single level-sensitive PCI interrupt line from two separate sources. The first is the interrupt level of the SCSI protocol core, which is mirrored into a status bit. The second is the sticky transfer-done flag, which only reaches the line when the done-interrupt enable in the command register is set.

The sticky status bits (error, abort, done) are cleared by write-one-to-clear. When the clear mode input is 0, reading the status register also clears them. The interrupt output is a register, and it is updated on the same edge as the status and command registers. As a result, every change to either register is reflected on the line with no added delay.

Top module: `dma_irq_comb`

## Requirements
- R1: Status bit 4 (core interrupt) takes the value of `scsi_irq_i` on each clock edge. It is set while that input is high and cleared once it is low, one cycle later.
- R2: `irq_o` always equals status bit 4 OR (status bit 3 AND command bit 7). It is re-evaluated on every change to the status or command register.
- R3: While command bit 7 (done-interrupt enable) is 0, a set done bit (status bit 3) does not raise `irq_o`.
- R4: A `xfer_done_i` pulse has three effects in the next cycle: it sets status bit 3, it zeroes the byte count register at offset 0x10, and it produces a one-cycle pulse on `cnt_clr_o`.
- R5: A write to the status register at offset 0x14 clears each of bits 0 (error), 1 (abort) and 3 (done) whose write-data bit is 1. Status bit 4 and the unused bits are not affected.
- R6: With `rd_keep_i` = 0, a status read returns the current value in the same cycle and then clears bits 0, 1 and 3.
- R7: With `rd_keep_i` = 1, a status read leaves the status register unchanged.
- R8: When a set event and a clear of the same sticky bit fall in the same cycle, the bit ends up set. The clear can come from a write or from a read.
- R9: `err_i` sets status bit 0, and `abort_i` sets status bit 1.
- R10: The asynchronous active-low reset clears the command, count and status registers, `irq_o` and `cnt_clr_o`.
- R11: The command register (offset 0x00) and the byte count register (offset 0x10) read back what was written. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| scsi_irq_i | input | 1 | SCSI core interrupt level |
| xfer_done_i | input | 1 | Transfer-complete pulse |
| err_i | input | 1 | DMA error event |
| abort_i | input | 1 | DMA abort event |
| rd_keep_i | input | 1 | 1: status reads have no side effect; 0: status reads clear sticky bits |
| irq_o | output | 1 | PCI interrupt level |
| cnt_clr_o | output | 1 | Pulse: byte count was zeroed by a transfer-complete |

## Verification
Setting the done flag and clearing it can fall into the same cycle. The clear can be a write-one-to-clear or a clearing status read. The bench provokes both cases by raising `xfer_done_i` in the very cycle that carries the status write with bit 3 set, and again in the cycle that carries a status read in clear mode. It then judges the outcome by reading the status back with side effects disabled and by watching `irq_o`, which must stay high while the done-interrupt enable is set.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_CMD  = 8'h00;
  localparam logic [OFS_W-1:0] OFS_CNT  = 8'h10;
  localparam logic [OFS_W-1:0] OFS_STAT = 8'h14;

  localparam int unsigned BIT_ERR  = 0;
  localparam int unsigned BIT_ABT  = 1;
  localparam int unsigned BIT_DONE = 3;
  localparam int unsigned BIT_CORE = 4;
  localparam int unsigned BIT_IEN  = 7;

  typedef struct packed {
    logic core;
    logic done;
    logic abt;
    logic err;
  } stat_t;
endpackage

// File: rtl/dma_stat_reg.sv
module dma_stat_reg
  import dma_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  core_irq_i,
  input  logic  set_done_i,
  input  logic  set_err_i,
  input  logic  set_abt_i,
  input  logic  clr_done_i,
  input  logic  clr_err_i,
  input  logic  clr_abt_i,
  output stat_t stat_q_o,
  output stat_t stat_d_o
);
  stat_t stat_q, stat_d;

  // set dominates clear
  always_comb begin
    stat_d.core = core_irq_i;
    stat_d.done = set_done_i | (stat_q.done & ~clr_done_i);
    stat_d.err  = set_err_i  | (stat_q.err  & ~clr_err_i);
    stat_d.abt  = set_abt_i  | (stat_q.abt  & ~clr_abt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_q_o = stat_q;
  assign stat_d_o = stat_d;

  p_core_mirror_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_irq_i |=> stat_q.core);
  p_core_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_irq_i |=> !stat_q.core);
  p_done_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_done_i |=> stat_q.done);
  p_err_abt_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_err_i && set_abt_i) |=> (stat_q.err && stat_q.abt));
endmodule

// File: rtl/dma_cmd_cnt.sv
module dma_cmd_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_we_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         done_i,
  input  logic [$clog2(W)-1:0] ien_bit_i,
  output logic [W-1:0] cmd_q_o,
  output logic         ien_d_o,
  output logic [W-1:0] cnt_q_o,
  output logic         cnt_clr_o
);
  logic [W-1:0] cmd_q, cmd_d, cnt_q;
  logic         clr_q;

  assign cmd_d   = cmd_we_i ? wdata_i : cmd_q;
  assign ien_d_o = cmd_d[ien_bit_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      cnt_q <= '0;
      clr_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      clr_q <= done_i;
      if (done_i)        cnt_q <= '0;   // completion beats a count write
      else if (cnt_we_i) cnt_q <= wdata_i;
    end
  end

  assign cmd_q_o   = cmd_q;
  assign cnt_q_o   = cnt_q;
  assign cnt_clr_o = clr_q;

  p_cnt_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (cnt_q == '0 && cnt_clr_o));
  p_cnt_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> !cnt_clr_o);
endmodule

// File: rtl/dma_irq_out.sv
module dma_irq_out
  import dma_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  stat_t stat_d_i,
  input  logic  ien_d_i,
  output logic  irq_o
);
  logic irq_q;

  // evaluated from next-state so the line moves on the same edge as the registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= stat_d_i.core | (stat_d_i.done & ien_d_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_irq_comb.sv
module dma_irq_comb
  import dma_irq_pkg::*;
#(
  parameter int unsigned DW = BUS_W,
  parameter int unsigned AW = OFS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  input  logic          scsi_irq_i,
  input  logic          xfer_done_i,
  input  logic          err_i,
  input  logic          abort_i,
  input  logic          rd_keep_i,
  output logic          irq_o,
  output logic          cnt_clr_o
);
  localparam int unsigned BW = $clog2(DW);
  localparam logic [BW-1:0] IEN_IDX = BW'(BIT_IEN);

  logic sel_cmd, sel_cnt, sel_stat;
  logic wr_stat, rd_clr;
  logic [DW-1:0] cmd_q, cnt_q, stat_word;
  logic ien_d;
  stat_t stat_q, stat_d;

  assign sel_cmd  = (addr_i == AW'(OFS_CMD));
  assign sel_cnt  = (addr_i == AW'(OFS_CNT));
  assign sel_stat = (addr_i == AW'(OFS_STAT));
  assign wr_stat  = wr_i & sel_stat;
  assign rd_clr   = rd_i & sel_stat & ~rd_keep_i;

  dma_stat_reg u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .core_irq_i (scsi_irq_i),
    .set_done_i (xfer_done_i),
    .set_err_i  (err_i),
    .set_abt_i  (abort_i),
    .clr_done_i ((wr_stat & wdata_i[BIT_DONE]) | rd_clr),
    .clr_err_i  ((wr_stat & wdata_i[BIT_ERR])  | rd_clr),
    .clr_abt_i  ((wr_stat & wdata_i[BIT_ABT])  | rd_clr),
    .stat_q_o   (stat_q),
    .stat_d_o   (stat_d)
  );

  dma_cmd_cnt #(.W(DW)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (wr_i & sel_cmd),
    .cnt_we_i  (wr_i & sel_cnt),
    .wdata_i   (wdata_i),
    .done_i    (xfer_done_i),
    .ien_bit_i (IEN_IDX),
    .cmd_q_o   (cmd_q),
    .ien_d_o   (ien_d),
    .cnt_q_o   (cnt_q),
    .cnt_clr_o (cnt_clr_o)
  );

  dma_irq_out u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stat_d_i (stat_d),
    .ien_d_i  (ien_d),
    .irq_o    (irq_o)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[BIT_ERR]  = stat_q.err;
    stat_word[BIT_ABT]  = stat_q.abt;
    stat_word[BIT_DONE] = stat_q.done;
    stat_word[BIT_CORE] = stat_q.core;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_cmd)  rdata_o = cmd_q;
    if (sel_cnt)  rdata_o = cnt_q;
    if (sel_stat) rdata_o = stat_word;
  end

  p_irq_combine_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (stat_q.core | (stat_q.done & cmd_q[BIT_IEN])));
  p_irq_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_q[BIT_IEN] && !stat_q.core) |-> !irq_o);
  p_wr_keeps_core_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && scsi_irq_i && stat_q.core) |=> stat_q.core);
  p_rd_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_stat && !rd_keep_i && !xfer_done_i && !err_i && !abort_i)
      |=> (!stat_q.err && !stat_q.abt && !stat_q.done));
  p_rd_noeffect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_stat && rd_keep_i && !wr_i && !xfer_done_i && !err_i && !abort_i)
      |=> $stable({stat_q.err, stat_q.abt, stat_q.done}));
endmodule

// File: tb/dma_irq_comb_tb.sv
`timescale 1ns/1ps
module dma_irq_comb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata;
  logic        scsi = 1'b0, done = 1'b0, err = 1'b0, abt = 1'b0, keep = 1'b1;
  logic        irq, cnt_clr;
  int          n_chk = 0, n_err = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_irq_comb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .scsi_irq_i(scsi),
    .xfer_done_i(done), .err_i(err), .abort_i(abt), .rd_keep_i(keep),
    .irq_o(irq), .cnt_clr_o(cnt_clr)
  );

  // kind: 0 idle, 1 write, 2 read (rdata checked)
  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        scsi, done, err, abt, keep;
    logic [31:0] exp_rd;
    logic        exp_irq;   // irq before this vector's edge
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 8'h14, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b0, 32'h00, 1'b0}, // R10 status zero
    '{2'd1, 8'h00, 32'h80, 1'b0,1'b0,1'b0,1'b0,1'b1, 32'h00, 1'b0}, // enable
    '{2'd2, 8'h00, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h80, 1'b0}, // R11
    '{2'd0, 8'h00, 32'h0,  1'b0,1'b1,1'b0,1'b0,1'b1, 32'h00, 1'b0}, // R4 done
    '{2'd2, 8'h14, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h08, 1'b1}, // R7
    '{2'd2, 8'h14, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h08, 1'b1}, // R7 still set
    '{2'd1, 8'h14, 32'h08, 1'b0,1'b0,1'b0,1'b0,1'b1, 32'h00, 1'b1}, // R5 clear done
    '{2'd2, 8'h14, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h00, 1'b0}, // R5 R2 dropped
    '{2'd0, 8'h00, 32'h0,  1'b1,1'b0,1'b0,1'b0,1'b1, 32'h00, 1'b0}, // R1 core high
    '{2'd2, 8'h14, 32'h0,  1'b1,1'b0,1'b0,1'b0,1'b1, 32'h10, 1'b1}, // R1
    '{2'd1, 8'h14, 32'hFF, 1'b1,1'b0,1'b0,1'b0,1'b1, 32'h00, 1'b1}, // R5 all ones
    '{2'd2, 8'h14, 32'h0,  1'b1,1'b0,1'b0,1'b0,1'b1, 32'h10, 1'b1}, // R5 core kept
    '{2'd0, 8'h00, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h00, 1'b1}, // R1 core low
    '{2'd2, 8'h14, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h00, 1'b0}, // R1
    '{2'd1, 8'h00, 32'h00, 1'b0,1'b0,1'b0,1'b0,1'b1, 32'h00, 1'b0}, // disable
    '{2'd0, 8'h00, 32'h0,  1'b0,1'b1,1'b0,1'b0,1'b1, 32'h00, 1'b0}, // done
    '{2'd2, 8'h14, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h08, 1'b0}, // R3 gated
    '{2'd1, 8'h00, 32'h80, 1'b0,1'b0,1'b0,1'b0,1'b1, 32'h00, 1'b0}, // R2 enable
    '{2'd2, 8'h14, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h08, 1'b1}, // R2 raised
    '{2'd0, 8'h00, 32'h0,  1'b0,1'b0,1'b1,1'b1,1'b1, 32'h00, 1'b1}, // R9
    '{2'd2, 8'h14, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0B, 1'b1}, // R9 R6 read-clear
    '{2'd2, 8'h14, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h00, 1'b0}, // R6 cleared
    '{2'd1, 8'h14, 32'h08, 1'b0,1'b1,1'b0,1'b0,1'b1, 32'h00, 1'b0}, // R8 write vs set
    '{2'd2, 8'h14, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h08, 1'b1}, // R8
    '{2'd1, 8'h14, 32'h01, 1'b0,1'b0,1'b0,1'b0,1'b1, 32'h00, 1'b1}, // R5 other bit only
    '{2'd2, 8'h14, 32'h0,  1'b0,1'b0,1'b0,1'b0,1'b1, 32'h08, 1'b1}  // R5 done kept
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    wr = 0; rd = 0; done = 0; err = 0; abt = 0; keep = 1; addr = '0; wdata = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 irq", {31'd0, irq}, 32'd0);
    chk("R10 cnt_clr", {31'd0, cnt_clr}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VECS[i].addr; wdata = VECS[i].wdata;
      wr = (VECS[i].kind == 2'd1); rd = (VECS[i].kind == 2'd2);
      scsi = VECS[i].scsi; done = VECS[i].done; err = VECS[i].err;
      abt = VECS[i].abt; keep = VECS[i].keep;
      #1;
      chk($sformatf("R2 irq vec %0d", i), {31'd0, irq}, {31'd0, VECS[i].exp_irq});
      if (VECS[i].kind == 2'd2)
        chk($sformatf("R%0d rdata vec %0d", i < 3 ? 11 : 6, i), rdata, VECS[i].exp_rd);
    end

    // R11 count register and unmapped offset
    @(negedge clk); idle_bus(); wr = 1; addr = 8'h10; wdata = 32'h0000_1234;
    @(negedge clk); idle_bus(); rd = 1; addr = 8'h10; #1;
    chk("R11 count readback", rdata, 32'h0000_1234);
    addr = 8'h04; #0.5;
    chk("R11 unmapped", rdata, 32'h0);

    // R4 completion zeroes count and pulses cnt_clr
    @(negedge clk); idle_bus(); done = 1; #1;
    chk("R4 cnt_clr before", {31'd0, cnt_clr}, 32'd0);
    @(negedge clk); idle_bus(); rd = 1; addr = 8'h10; #1;
    chk("R4 count zero", rdata, 32'h0);
    chk("R4 cnt_clr pulse", {31'd0, cnt_clr}, 32'd1);
    @(negedge clk); idle_bus(); #1;
    chk("R4 cnt_clr single", {31'd0, cnt_clr}, 32'd0);

    // R8 clearing read in same cycle as completion: done survives
    @(negedge clk); idle_bus(); rd = 1; addr = 8'h14; keep = 0; err = 0; done = 1; #1;
    chk("R6 rdata before", rdata, 32'h08);
    @(negedge clk); idle_bus(); rd = 1; addr = 8'h14; #1;
    chk("R8 read vs set", rdata, 32'h08);
    chk("R8 irq held", {31'd0, irq}, 32'd1);

    // R10 mid-run reset
    @(negedge clk); idle_bus(); scsi = 1;
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R10 irq after reset", {31'd0, irq}, 32'd0);
    rd = 1; addr = 8'h00; #0.5;
    chk("R10 cmd after reset", rdata, 32'h0);
    addr = 8'h14; #0.5;
    chk("R10 stat after reset", rdata, 32'h0);
    scsi = 0;
    @(negedge clk); rst_n = 1'b1; idle_bus();
    @(negedge clk);
    finish_run();
  end
endmodule